// File: doc/BRIEF.md
# S-Record Stream Loader

This block takes a stream of ASCII characters, one per handshake beat, and reads S-record text from it. Every record opens with the letter `S` and a type digit. The rest of the record is hex digit pairs: a length byte, a big-endian address, the payload bytes and a closing integrity byte. Records of type 1, 2 and 3 carry memory contents. For each of these the block issues one byte-wide write per payload byte, to addresses that ascend from the record's own address. Records of any other type go through the same parsing and integrity check, and then the block drops them.

The payload is held in a small staging buffer while the record arrives. The block writes it out only after the closing byte proves correct, so a corrupted record never changes memory. While the writes go out the block stops accepting characters. It skips line breaks between records. A stray character, a malformed length or a failed integrity check each raise their own one-cycle pulse. After a character fault the parser throws away the rest of that line.

Top module: `srec_parser`

## Requirements
- R1: Between records, LF (0x0A) and CR (0x0D) are skipped with no pulse. `S` (0x53) opens a record. Any other character pulses `fmt_err_o` once, and the rest of that line up to the next CR or LF is discarded with no further pulse.
- R2: The character after `S` must be an ASCII digit `0`–`9` (0x30–0x39). Anything else pulses `fmt_err_o` and abandons the record.
- R3: Type 1 uses a 2-byte address, type 2 a 3-byte address and type 3 a 4-byte address, each sent most significant byte first. Types 7 and 3 share the 4-byte length, types 6 and 8 use 3 bytes, and types 0, 4, 5 and 9 use 2 bytes.
- R4: Hex digits are accepted in both cases (0-9, A-F, a-f), two digits per byte with the high nibble first. Any other character inside a record pulses `fmt_err_o` and abandons the record.
- R5: The length byte counts the address, payload and integrity bytes. A length smaller than the address length plus one pulses `fmt_err_o` once its second digit is accepted, and so does a load record whose payload would exceed DATA_DEPTH (default 16).
- R6: A record is valid when its last byte equals the bitwise inverse of the low 8 bits of the sum of the length, address and payload bytes. Otherwise `cksum_err_o` pulses and no write is issued.
- R7: For a valid record, `rec_ok_o` pulses in the cycle after the last digit is accepted. For types 1–3 the writes start in that same cycle, one per cycle in payload order, at the record address plus 0, 1, 2 and so on (32-bit).
- R8: Valid records of types other than 1, 2 and 3 pulse `rec_ok_o` and issue no write.
- R9: `ch_ready_o` is low in exactly the cycles in which writes are being issued, and high again in the cycle after the last write.
- R10: After reset `ch_ready_o` is high and no write or pulse is active. A record that reset cuts short leaves no trace.
- R11: A valid load record with no payload bytes pulses `rec_ok_o` and issues no write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ch_i | input | 8 | ASCII character |
| ch_valid_i | input | 1 | Character valid |
| ch_ready_o | output | 1 | Character accepted when high with valid |
| wr_valid_o | output | 1 | Memory write strobe |
| wr_addr_o | output | 32 | Write byte address |
| wr_data_o | output | 8 | Write byte |
| rec_ok_o | output | 1 | Pulse: record passed its integrity check |
| cksum_err_o | output | 1 | Pulse: integrity byte mismatch |
| fmt_err_o | output | 1 | Pulse: illegal character or length |

## Verification
The vector table covers the three load types, each with a distinct address length and letter case, so a wrong address length or a byte-order slip shows up as a wrong write address. Good records of other types and a load record with no payload tell a record that should be dropped apart from one that should be written. The table then varies the records in ways that each trip exactly one fault class: one integrity value off by one, a bad hex digit, a bad type, a length that is too short, a length that is too long, and junk between records. It also includes a payload of exactly the buffer size. Directed cases pin the cycle of the first write and the ready drop, and check that a record cut off by reset is lost.

// File: rtl/srec_pkg.sv
package srec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TYPE,
    ST_BODY,
    ST_COMMIT,
    ST_SKIP
  } st_e;

  function automatic logic is_eol(input logic [7:0] c);
    return (c == 8'h0A) || (c == 8'h0D);
  endfunction

  function automatic logic is_digit(input logic [7:0] c);
    return (c >= 8'h30) && (c <= 8'h39);
  endfunction

  // address bytes per record type
  function automatic logic [2:0] addr_len(input logic [3:0] t);
    case (t)
      4'd2, 4'd6, 4'd8: return 3'd3;
      4'd3, 4'd7:       return 3'd4;
      default:          return 3'd2;
    endcase
  endfunction

  function automatic logic is_load(input logic [3:0] t);
    return t inside {4'd1, 4'd2, 4'd3};
  endfunction

endpackage

// File: rtl/srec_nib_dec.sv
module srec_nib_dec (
  input  logic [7:0] ch_i,
  output logic [3:0] nib_o,
  output logic       hex_o
);
  always_comb begin
    nib_o = 4'd0;
    hex_o = 1'b1;
    if (ch_i >= 8'h30 && ch_i <= 8'h39)      nib_o = ch_i[3:0];
    else if (ch_i >= 8'h41 && ch_i <= 8'h46) nib_o = ch_i[3:0] + 4'd9;
    else if (ch_i >= 8'h61 && ch_i <= 8'h66) nib_o = ch_i[3:0] + 4'd9;
    else                                     hex_o = 1'b0;
  end
endmodule

// File: rtl/srec_stage_buf.sv
module srec_stage_buf #(
  parameter int DEPTH = 16,
  localparam int IW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] wr_idx_i,
  input  logic [7:0]    wr_byte_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [7:0]    rd_byte_o
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_byte_i;
  end

  assign rd_byte_o = mem_q[rd_idx_i];
endmodule

// File: rtl/srec_parser.sv
module srec_parser
  import srec_pkg::*;
#(
  parameter int DATA_DEPTH = 16,
  localparam int BW = $clog2(DATA_DEPTH),
  localparam int AW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [7:0]    ch_i,
  input  logic          ch_valid_i,
  output logic          ch_ready_o,
  output logic          wr_valid_o,
  output logic [AW-1:0] wr_addr_o,
  output logic [7:0]    wr_data_o,
  output logic          rec_ok_o,
  output logic          cksum_err_o,
  output logic          fmt_err_o
);

  st_e           st_q;
  logic [3:0]    type_q;
  logic          phase_q;
  logic [3:0]    hi_q;
  logic          cnt_done_q;
  logic [7:0]    rem_q;
  logic [2:0]    addr_left_q;
  logic [7:0]    sum_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    ndata_q;
  logic [7:0]    wr_ptr_q;
  logic [7:0]    rd_q;
  logic          ok_q, ck_q, fe_q;

  logic [3:0] nib_w;
  logic       hex_w;
  logic [7:0] byte_w;
  logic       accept_w, eol_w, load_w, buf_we_w, cnt_short_w, cnt_long_w;
  logic [2:0] alen_w;
  logic [7:0] rd_byte_w;

  srec_nib_dec u_nib (
    .ch_i  (ch_i),
    .nib_o (nib_w),
    .hex_o (hex_w)
  );

  assign ch_ready_o  = (st_q != ST_COMMIT);
  assign accept_w    = ch_valid_i && ch_ready_o;
  assign eol_w       = is_eol(ch_i);
  assign byte_w      = {hi_q, nib_w};
  assign alen_w      = addr_len(type_q);
  assign load_w      = is_load(type_q);
  assign cnt_short_w = {1'b0, byte_w} < (9'(alen_w) + 9'd1);
  assign cnt_long_w  = load_w && ({1'b0, byte_w} > (9'(DATA_DEPTH) + 9'(alen_w) + 9'd1));

  // payload byte lands in the staging buffer
  assign buf_we_w = accept_w && (st_q == ST_BODY) && hex_w && phase_q && cnt_done_q &&
                    (addr_left_q == 3'd0) && (rem_q != 8'd1) && load_w;

  srec_stage_buf #(.DEPTH(DATA_DEPTH)) u_buf (
    .clk_i     (clk_i),
    .we_i      (buf_we_w),
    .wr_idx_i  (wr_ptr_q[BW-1:0]),
    .wr_byte_i (byte_w),
    .rd_idx_i  (rd_q[BW-1:0]),
    .rd_byte_o (rd_byte_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      type_q      <= 4'd0;
      phase_q     <= 1'b0;
      hi_q        <= 4'd0;
      cnt_done_q  <= 1'b0;
      rem_q       <= 8'd0;
      addr_left_q <= 3'd0;
      sum_q       <= 8'd0;
      addr_q      <= '0;
      ndata_q     <= 8'd0;
      wr_ptr_q    <= 8'd0;
      rd_q        <= 8'd0;
      ok_q        <= 1'b0;
      ck_q        <= 1'b0;
      fe_q        <= 1'b0;
    end else begin
      ok_q <= 1'b0;
      ck_q <= 1'b0;
      fe_q <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept_w) begin
          if (ch_i == 8'h53) st_q <= ST_TYPE;
          else if (!eol_w) begin
            fe_q <= 1'b1;
            st_q <= ST_SKIP;
          end
        end
        ST_TYPE: if (accept_w) begin
          if (is_digit(ch_i)) begin
            type_q     <= ch_i[3:0];
            st_q       <= ST_BODY;
            phase_q    <= 1'b0;
            cnt_done_q <= 1'b0;
            wr_ptr_q   <= 8'd0;
          end else begin
            fe_q <= 1'b1;
            st_q <= eol_w ? ST_IDLE : ST_SKIP;
          end
        end
        ST_BODY: if (accept_w) begin
          if (!hex_w) begin
            fe_q <= 1'b1;
            st_q <= eol_w ? ST_IDLE : ST_SKIP;
          end else if (!phase_q) begin
            hi_q    <= nib_w;
            phase_q <= 1'b1;
          end else begin
            phase_q <= 1'b0;
            if (!cnt_done_q) begin
              if (cnt_short_w || cnt_long_w) begin
                fe_q <= 1'b1;
                st_q <= ST_SKIP;
              end else begin
                cnt_done_q  <= 1'b1;
                rem_q       <= byte_w;
                sum_q       <= byte_w;
                addr_left_q <= alen_w;
                addr_q      <= '0;
                ndata_q     <= byte_w - 8'(alen_w) - 8'd1;
              end
            end else if (addr_left_q != 3'd0) begin
              addr_q      <= {addr_q[AW-9:0], byte_w};
              addr_left_q <= addr_left_q - 3'd1;
              sum_q       <= sum_q + byte_w;
              rem_q       <= rem_q - 8'd1;
            end else if (rem_q != 8'd1) begin
              sum_q <= sum_q + byte_w;
              rem_q <= rem_q - 8'd1;
              if (load_w) wr_ptr_q <= wr_ptr_q + 8'd1;
            end else if (byte_w == ~sum_q) begin
              ok_q <= 1'b1;
              rd_q <= 8'd0;
              st_q <= (load_w && ndata_q != 8'd0) ? ST_COMMIT : ST_IDLE;
            end else begin
              ck_q <= 1'b1;
              st_q <= ST_IDLE;
            end
          end
        end
        ST_COMMIT: begin
          rd_q <= rd_q + 8'd1;
          if (rd_q == ndata_q - 8'd1) st_q <= ST_IDLE;
        end
        ST_SKIP: if (accept_w && eol_w) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_valid_o  = (st_q == ST_COMMIT);
  assign wr_addr_o   = addr_q + AW'(rd_q);
  assign wr_data_o   = rd_byte_w;
  assign rec_ok_o    = ok_q;
  assign cksum_err_o = ck_q;
  assign fmt_err_o   = fe_q;

  // R1 R6 R7: at most one outcome pulse per cycle
  a_r1_one_outcome: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({rec_ok_o, cksum_err_o, fmt_err_o}));

  a_r7_first_write_with_ok: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wr_valid_o) |-> rec_ok_o);

  a_r7_addr_ascend: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && $past(wr_valid_o)) |-> (wr_addr_o == $past(wr_addr_o) + 32'd1));

  a_r6_bad_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cksum_err_o |-> !wr_valid_o);

  a_r8_nonload_no_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_ok_o && !is_load(type_q)) |-> !wr_valid_o);

  a_r9_ready_back: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wr_valid_o) |-> ch_ready_o);

  a_r5_buf_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    buf_we_w |-> (wr_ptr_q < 8'(DATA_DEPTH)));

endmodule

// File: tb/srec_parser_bench.sv
module srec_parser_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 13;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [7:0]  ch_i = 8'd0;
  logic        ch_valid_i = 1'b0;
  logic        ch_ready_o, wr_valid_o, rec_ok_o, cksum_err_o, fmt_err_o;
  logic [31:0] wr_addr_o;
  logic [7:0]  wr_data_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  srec_parser u_srec_parser (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ch_i        (ch_i),
    .ch_valid_i  (ch_valid_i),
    .ch_ready_o  (ch_ready_o),
    .wr_valid_o  (wr_valid_o),
    .wr_addr_o   (wr_addr_o),
    .wr_data_o   (wr_data_o),
    .rec_ok_o    (rec_ok_o),
    .cksum_err_o (cksum_err_o),
    .fmt_err_o   (fmt_err_o)
  );

  // kind: 0 good, 1 integrity error, 2 format error
  localparam logic [383:0] T_REC [NV] = '{
    "S1051000AABB85",
    "S2060123455A3CFA",
    "S306deadbeef7e43",
    "S1051000AABB86",
    "S0050000484969",
    "S9030000FC",
    "S1032000DC",
    "S1051G00AABB85",
    "SZ0300",
    "S304000000FB",
    "S1140000",
    "S1130000000102030405060708090A0B0C0D0E0F74",
    "X12"
  };
  localparam logic [1:0] T_KIND [NV] = '{0, 0, 0, 1, 0, 0, 0, 2, 2, 2, 2, 0, 2};
  localparam int T_NWR [NV] = '{2, 2, 1, 0, 0, 0, 0, 0, 0, 0, 0, 16, 0};
  localparam logic [31:0] T_ADDR [NV] = '{32'h1000, 32'h12345, 32'hDEADBEEF, 0, 0, 0, 0,
                                         0, 0, 0, 0, 32'h0, 0};
  localparam logic [127:0] T_DATA [NV] = '{128'hBBAA, 128'h3C5A, 128'h7E, 0, 0, 0, 0, 0, 0, 0,
                                          0, 128'h0F0E0D0C0B0A09080706050403020100, 0};
  localparam string T_REQ [NV] = '{"R3", "R3", "R4", "R6", "R8", "R8", "R11", "R4", "R2",
                                   "R5", "R5", "R5", "R1"};

  int n_chk = 0, n_bad = 0;
  int ok_cnt = 0, ck_cnt = 0, fe_cnt = 0, w_cnt = 0;
  logic [31:0] cap_addr [64];
  logic [7:0]  cap_data [64];
  bit done = 0;

  always @(negedge clk) begin
    if (rst_ni) begin
      if (wr_valid_o) begin
        cap_addr[w_cnt % 64] = wr_addr_o;
        cap_data[w_cnt % 64] = wr_data_o;
        w_cnt = w_cnt + 1;
      end
      if (rec_ok_o)    ok_cnt = ok_cnt + 1;
      if (cksum_err_o) ck_cnt = ck_cnt + 1;
      if (fmt_err_o)   fe_cnt = fe_cnt + 1;
    end
  end

  task automatic chk(input bit cond, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!cond) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_char(input logic [7:0] c);
    while (!ch_ready_o) @(negedge clk);
    ch_i = c;
    ch_valid_i = 1'b1;
    @(negedge clk);
    ch_valid_i = 1'b0;
  endtask

  task automatic send_text(input logic [383:0] t);
    for (int i = 47; i >= 0; i--) begin
      if (t[8*i +: 8] != 8'd0) send_char(t[8*i +: 8]);
    end
  endtask

  task automatic send_eol();
    send_char(8'h0D);
    send_char(8'h0A);
    repeat (24) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_chk++;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int ok0, ck0, fe0, w0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(ch_ready_o && !wr_valid_o && !rec_ok_o && !cksum_err_o && !fmt_err_o, "R10",
        {ch_ready_o, wr_valid_o, rec_ok_o, cksum_err_o, fmt_err_o}, 5'b10000);

    for (int v = 0; v < NV; v++) begin
      ok0 = ok_cnt; ck0 = ck_cnt; fe0 = fe_cnt; w0 = w_cnt;
      send_text(T_REC[v]);
      send_eol();
      chk((ok_cnt - ok0 == int'(T_KIND[v] == 0)) && (ck_cnt - ck0 == int'(T_KIND[v] == 1)) &&
          (fe_cnt - fe0 == int'(T_KIND[v] == 2)), T_REQ[v],
          64'({ok_cnt - ok0, ck_cnt - ck0, fe_cnt - fe0}), 64'(T_KIND[v]));
      chk(w_cnt - w0 == T_NWR[v], "R7", 64'(w_cnt - w0), 64'(T_NWR[v]));
      for (int j = 0; j < T_NWR[v] && j < w_cnt - w0; j++) begin
        chk(cap_addr[(w0 + j) % 64] == T_ADDR[v] + 32'(j) &&
            cap_data[(w0 + j) % 64] == T_DATA[v][8*j +: 8], "R7",
            {cap_addr[(w0 + j) % 64], 24'd0, cap_data[(w0 + j) % 64]},
            {T_ADDR[v] + 32'(j), 24'd0, T_DATA[v][8*j +: 8]});
      end
    end

    // R7 R9: write timing relative to the last digit
    send_text("S1051000AABB85");
    chk(rec_ok_o && wr_valid_o && !ch_ready_o && wr_addr_o == 32'h1000 && wr_data_o == 8'hAA,
        "R7", {rec_ok_o, wr_valid_o, ch_ready_o, wr_addr_o, wr_data_o}, {3'b110, 32'h1000, 8'hAA});
    @(negedge clk);
    chk(!rec_ok_o && wr_valid_o && !ch_ready_o && wr_addr_o == 32'h1001 && wr_data_o == 8'hBB,
        "R9", {rec_ok_o, wr_valid_o, ch_ready_o, wr_addr_o, wr_data_o}, {3'b010, 32'h1001, 8'hBB});
    @(negedge clk);
    chk(!wr_valid_o && ch_ready_o, "R9", {wr_valid_o, ch_ready_o}, 2'b01);
    send_eol();

    // R10 record cut by reset leaves no trace
    send_text("S10510");
    rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    ok0 = ok_cnt; ck0 = ck_cnt; fe0 = fe_cnt; w0 = w_cnt;
    send_text("S1032000DC");
    send_eol();
    chk(ok_cnt - ok0 == 1 && fe_cnt == fe0 && ck_cnt == ck0 && w_cnt == w0, "R10",
        64'({ok_cnt - ok0, fe_cnt - fe0, ck_cnt - ck0, w_cnt - w0}), 64'h1_0000_0000_0000);

    // R2 line break right after S abandons the record
    fe0 = fe_cnt; ok0 = ok_cnt;
    send_char("S");
    send_eol();
    chk(fe_cnt - fe0 == 1 && ok_cnt == ok0, "R2", 64'(fe_cnt - fe0), 64'd1);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule